// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block moves a system clock safely from one PLL setting to another without firmware doing the stepping. A one-cycle start pulse captures three request values: a new reference-source code, a packed multiplier/divider word and a window value for the external frequency checker. The sequencer then walks the PLL controls through a fixed order. It takes the system clock off the PLL and powers the PLL down. It changes the reference source and forces the system divider to divide-by-1. It writes the whole configuration word in one strobe, which also powers the PLL back up. It then waits for lock, asks the external checker for a verdict and hands the system clock back to the PLL only when that verdict is a pass.

A timed-out lock or a failed verdict powers the PLL down again and repeats the configuration write. The reference source is left as it is. After a set number of retries the block gives up, raises a sticky error flag and leaves the PLL bypassed and powered off. The analog PLL and the frequency counter sit outside the block.

The states are IDLE, BYPASS, PWRDN, SRCSEL, DIVSET, CFGWR, LOCKWAIT, FCHKGO and FCHKWAIT. Their transitions are:
- IDLE→BYPASS when a start is accepted.
- BYPASS→PWRDN after `BYP_WAIT` cycles.
- PWRDN→SRCSEL after `PD_WAIT` cycles on a first attempt, or PWRDN→DIVSET on a retry.
- SRCSEL→DIVSET after `SRC_WAIT` cycles.
- DIVSET→CFGWR and CFGWR→LOCKWAIT, one cycle each.
- LOCKWAIT→FCHKGO when lock is seen, or LOCKWAIT→PWRDN/IDLE after `LOCK_TO` cycles without lock.
- FCHKGO→FCHKWAIT after one cycle.
- FCHKWAIT→IDLE on a pass, or FCHKWAIT→PWRDN/IDLE on a fail.

A failure goes to PWRDN while retries remain and to IDLE (error) once they are used up.

Top module: `pll_seq`

## Requirements
- R1: After reset the PLL clock enable and PLL power enable are 0. The divider code is 0 (code 0 means divide-by-1). The source code equals `SRC_RESET` (default 0, the internal oscillator divided by 4). busy, done and error are 0.
- R2: An accepted start raises busy and drops the PLL clock enable on the same edge. The PLL power enable then falls exactly `BYP_WAIT` (120) cycles later.
- R3: The source output takes the requested code exactly `PD_WAIT` (66) cycles after the power-down. It changes only while both PLL enables are 0.
- R4: `SRC_WAIT` (60) cycles after the source change, the divider is set to code 0 for one cycle. The next cycle carries a one-cycle configuration strobe. During that strobe the captured word is on the word output and the PLL power enable is 1.
- R5: A lock input seen high in LOCKWAIT gives a one-cycle check-start pulse on the next cycle. The captured window value is presented with that pulse.
- R6: A check result with pass=1 sets the PLL clock enable and done on the edge that samples it. The PLL clock enable never rises otherwise.
- R7: A failed check, or `LOCK_TO` cycles in LOCKWAIT without lock, drops the PLL power enable on the next edge. After `PD_WAIT` more cycles plus one DIVSET cycle, the block issues a new configuration strobe and leaves the source unchanged.
- R8: A failure after `MAX_RETRY` retries (default 2, so 3 attempts in total) sets error and returns to idle with both PLL enables at 0.
- R9: A start pulse while busy changes nothing: not the sequence timing, nor the source or word that is applied.
- R10: done and error stay set until the next accepted start, which clears both. They are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| src_sel_i | input | SRC_W | Requested reference-source code |
| cfg_word_i | input | CFG_W | Packed multiplier/divider word |
| chk_window_i | input | WIN_W | Frequency-check window value |
| lock_i | input | 1 | PLL lock status |
| fchk_done_i | input | 1 | Frequency-check result valid |
| fchk_pass_i | input | 1 | Frequency-check verdict, 1 = in range |
| pll_clk_en_o | output | 1 | 1 = system clock taken from PLL |
| pll_pwr_en_o | output | 1 | PLL power enable |
| src_sel_o | output | SRC_W | Applied reference-source code |
| sys_div_o | output | DIV_W | System divider code, 0 = divide-by-1 |
| cfg_word_o | output | CFG_W | Applied configuration word |
| cfg_wr_o | output | 1 | One-cycle configuration strobe |
| fchk_start_o | output | 1 | One-cycle frequency-check start |
| fchk_window_o | output | WIN_W | Window for the frequency checker |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky success flag |
| err_o | output | 1 | Sticky failure flag |

## Verification
The bench checks the exact gaps between successive control changes. A design with an off-by-one settle counter, or one that skips the bypass while the PLL is already powered, shows a shifted or missing event against the expected timeline. Runs that mix a failed verdict with a lock timeout check two things. A design that went back through source selection on a retry would emit an unexpected source event. A design that counted attempts wrongly would report error one attempt early or late. A start pulse issued mid-sequence with different request values catches a design that re-captures while busy. The run that follows an error checks that done and error are cleared by the next start and not before it.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BYPASS,
        ST_PWRDN,
        ST_SRCSEL,
        ST_DIVSET,
        ST_CFGWR,
        ST_LOCKWAIT,
        ST_FCHKGO,
        ST_FCHKWAIT
    } seq_state_e;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/pll_seq_retry.sv
module pll_seq_retry #(
    parameter int MAX_RETRY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic exhausted
);
    localparam int RETRY_W = $clog2(MAX_RETRY + 2);

    logic [RETRY_W-1:0] tries_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries_q <= '0;
        end else if (clr) begin
            tries_q <= '0;
        end else if (bump && !exhausted) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    assign exhausted = (tries_q == RETRY_W'(MAX_RETRY));

    // R8
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q <= RETRY_W'(MAX_RETRY));
endmodule

// File: rtl/pll_seq.sv
module pll_seq #(
    parameter int SRC_W     = 2,
    parameter int CFG_W     = 32,
    parameter int WIN_W     = 16,
    parameter int DIV_W     = 6,
    parameter int BYP_WAIT  = 120,
    parameter int PD_WAIT   = 66,
    parameter int SRC_WAIT  = 60,
    parameter int LOCK_TO   = 4096,
    parameter int MAX_RETRY = 2,
    parameter int SRC_RESET = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SRC_W-1:0] src_sel_i,
    input  logic [CFG_W-1:0] cfg_word_i,
    input  logic [WIN_W-1:0] chk_window_i,
    input  logic             lock_i,
    input  logic             fchk_done_i,
    input  logic             fchk_pass_i,
    output logic             pll_clk_en_o,
    output logic             pll_pwr_en_o,
    output logic [SRC_W-1:0] src_sel_o,
    output logic [DIV_W-1:0] sys_div_o,
    output logic [CFG_W-1:0] cfg_word_o,
    output logic             cfg_wr_o,
    output logic             fchk_start_o,
    output logic [WIN_W-1:0] fchk_window_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    import pll_seq_pkg::*;

    localparam int MAX_A   = (BYP_WAIT > PD_WAIT) ? BYP_WAIT : PD_WAIT;
    localparam int MAX_B   = (SRC_WAIT > LOCK_TO) ? SRC_WAIT : LOCK_TO;
    localparam int MAX_WT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_WT + 2);
    localparam logic [DIV_W-1:0] DIV_ONE = '0;

    seq_state_e       state_q, state_n;
    logic             retrying_q;
    logic [SRC_W-1:0] req_src_q;
    logic [CFG_W-1:0] req_cfg_q;
    logic [WIN_W-1:0] req_win_q;
    logic [CNT_W-1:0] wait_lim;
    logic             tmr_exp, exhausted;
    logic             accept, pass, fail, retry, give_up;

    assign accept  = start_i && (state_q == ST_IDLE);
    assign pass    = (state_q == ST_FCHKWAIT) && fchk_done_i && fchk_pass_i;
    assign fail    = ((state_q == ST_LOCKWAIT) && !lock_i && tmr_exp) ||
                     ((state_q == ST_FCHKWAIT) && fchk_done_i && !fchk_pass_i);
    assign retry   = fail && !exhausted;
    assign give_up = fail && exhausted;

    always_comb begin
        unique case (state_q)
            ST_BYPASS:   wait_lim = CNT_W'(BYP_WAIT);
            ST_PWRDN:    wait_lim = CNT_W'(PD_WAIT);
            ST_SRCSEL:   wait_lim = CNT_W'(SRC_WAIT);
            ST_LOCKWAIT: wait_lim = CNT_W'(LOCK_TO);
            default:     wait_lim = CNT_W'(1);
        endcase
    end

    pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_n != state_q),
        .limit   (wait_lim),
        .expired (tmr_exp)
    );

    pll_seq_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .bump      (retry),
        .exhausted (exhausted)
    );

    // Next-state decode
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_n = ST_BYPASS;
            ST_BYPASS:   if (tmr_exp) state_n = ST_PWRDN;
            ST_PWRDN:    if (tmr_exp) state_n = retrying_q ? ST_DIVSET : ST_SRCSEL;
            ST_SRCSEL:   if (tmr_exp) state_n = ST_DIVSET;
            ST_DIVSET:   state_n = ST_CFGWR;
            ST_CFGWR:    state_n = ST_LOCKWAIT;
            ST_LOCKWAIT: begin
                if (lock_i)       state_n = ST_FCHKGO;
                else if (give_up) state_n = ST_IDLE;
                else if (retry)   state_n = ST_PWRDN;
            end
            ST_FCHKGO:   state_n = ST_FCHKWAIT;
            ST_FCHKWAIT: begin
                if (pass || give_up) state_n = ST_IDLE;
                else if (retry)      state_n = ST_PWRDN;
            end
            default:     state_n = ST_IDLE;
        endcase
    end

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            retrying_q <= 1'b0;
            req_src_q  <= SRC_W'(SRC_RESET);
            req_cfg_q  <= '0;
            req_win_q  <= '0;
        end else begin
            state_q <= state_n;
            if (accept) begin
                retrying_q <= 1'b0;
                req_src_q  <= src_sel_i;
                req_cfg_q  <= cfg_word_i;
                req_win_q  <= chk_window_i;
            end else if (retry) begin
                retrying_q <= 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_clk_en_o  <= 1'b0;
            pll_pwr_en_o  <= 1'b0;
            src_sel_o     <= SRC_W'(SRC_RESET);
            sys_div_o     <= DIV_ONE;
            cfg_word_o    <= '0;
            cfg_wr_o      <= 1'b0;
            fchk_start_o  <= 1'b0;
            fchk_window_o <= '0;
            busy_o        <= 1'b0;
            done_o        <= 1'b0;
            err_o         <= 1'b0;
        end else begin
            cfg_wr_o     <= (state_n == ST_CFGWR);
            fchk_start_o <= (state_n == ST_FCHKGO);
            busy_o       <= (state_n != ST_IDLE);
            if (accept)     pll_clk_en_o <= 1'b0;
            else if (pass)  pll_clk_en_o <= 1'b1;
            if ((state_n == ST_PWRDN && state_q != ST_PWRDN) || give_up)
                pll_pwr_en_o <= 1'b0;
            else if (state_n == ST_CFGWR)
                pll_pwr_en_o <= 1'b1;
            if (state_n == ST_SRCSEL && state_q != ST_SRCSEL) src_sel_o <= req_src_q;
            if (state_n == ST_DIVSET) sys_div_o <= DIV_ONE;
            if (state_n == ST_CFGWR)  cfg_word_o <= req_cfg_q;
            if (state_n == ST_FCHKGO) fchk_window_o <= req_win_q;
            if (accept) begin
                done_o <= 1'b0;
                err_o  <= 1'b0;
            end else begin
                if (pass)    done_o <= 1'b1;
                if (give_up) err_o  <= 1'b1;
            end
        end
    end

    // R6
    clk_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_clk_en_o) |-> $past(fchk_done_i && fchk_pass_i));
    // R3
    src_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_sel_o) |-> (!pll_clk_en_o && !pll_pwr_en_o));
    // R4
    cfg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |-> (pll_pwr_en_o && !pll_clk_en_o && sys_div_o == DIV_ONE));
    // R5
    fchk_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fchk_start_o |-> $past(lock_i));
    // R8
    err_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !pll_clk_en_o);
    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));
    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(cfg_word_o));
endmodule

// File: tb/tb_pll_seq.sv
module tb_pll_seq;
    localparam int SRC_W = 2, CFG_W = 32, WIN_W = 16, DIV_W = 6;
    localparam int LOCK_TO = 40;
    localparam int EV_BUSY = 0, EV_BYP = 1, EV_PD = 2, EV_SRC = 3,
                   EV_CFG = 4, EV_FCHK = 5, EV_DONE = 6, EV_ERR = 7;

    logic             clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
    logic [SRC_W-1:0] src_sel_i = '0;
    logic [CFG_W-1:0] cfg_word_i = '0;
    logic [WIN_W-1:0] chk_window_i = '0;
    logic             lock_i = 1'b0, fchk_done_i = 1'b0, fchk_pass_i = 1'b0;
    logic             pll_clk_en_o, pll_pwr_en_o, cfg_wr_o, fchk_start_o;
    logic [SRC_W-1:0] src_sel_o;
    logic [DIV_W-1:0] sys_div_o;
    logic [CFG_W-1:0] cfg_word_o;
    logic [WIN_W-1:0] fchk_window_o;
    logic             busy_o, done_o, err_o;

    pll_seq #(.SRC_W(SRC_W), .CFG_W(CFG_W), .WIN_W(WIN_W), .DIV_W(DIV_W),
              .LOCK_TO(LOCK_TO), .MAX_RETRY(2)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_sel_i(src_sel_i),
        .cfg_word_i(cfg_word_i), .chk_window_i(chk_window_i), .lock_i(lock_i),
        .fchk_done_i(fchk_done_i), .fchk_pass_i(fchk_pass_i),
        .pll_clk_en_o(pll_clk_en_o), .pll_pwr_en_o(pll_pwr_en_o),
        .src_sel_o(src_sel_o), .sys_div_o(sys_div_o), .cfg_word_o(cfg_word_o),
        .cfg_wr_o(cfg_wr_o), .fchk_start_o(fchk_start_o),
        .fchk_window_o(fchk_window_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

    always #4 clk = ~clk;

    typedef struct { int kind; int delta; string req; } exp_t;
    exp_t sb[$];
    int n_chk = 0, n_fail = 0, cyc = 0, last_ev = 0;
    bit finished = 0;
    int lock_dly[3];
    bit pass_pl[3];
    int att = 0, lock_cnt = -1, fc_cnt = -1;
    bit fc_pass = 0;
    logic p_busy = 0, p_clk = 0, p_pwr = 0, p_done = 0, p_err = 0;
    logic [SRC_W-1:0] p_src = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(int kind, int delta, string req);
        exp_t e;
        e.kind = kind; e.delta = delta; e.req = req;
        sb.push_back(e);
    endtask

    task automatic ev(int kind);
        exp_t e;
        if (sb.size() == 0) begin
            chk(0, "R9", "unexpected event", kind, -1);
        end else begin
            e = sb.pop_front();
            chk(e.kind == kind, e.req, "event kind", kind, e.kind);
            if (e.delta >= 0)
                chk(cyc - last_ev == e.delta, e.req, "event gap", cyc - last_ev, e.delta);
        end
        last_ev = cyc;
    endtask

    // Monitor: ordered event detection against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o && !p_busy)         ev(EV_BUSY);
            if (!pll_clk_en_o && p_clk)    ev(EV_BYP);
            if (!pll_pwr_en_o && p_pwr)    ev(EV_PD);
            if (src_sel_o != p_src)        ev(EV_SRC);
            if (cfg_wr_o)                  ev(EV_CFG);
            if (fchk_start_o)              ev(EV_FCHK);
            if (done_o && !p_done)         ev(EV_DONE);
            if (err_o && !p_err)           ev(EV_ERR);
        end
        p_busy = busy_o; p_clk = pll_clk_en_o; p_pwr = pll_pwr_en_o;
        p_src = src_sel_o; p_done = done_o; p_err = err_o;
    end

    // PLL and frequency-checker models
    always @(negedge clk) begin
        if (cfg_wr_o) begin
            lock_cnt = lock_dly[att];
            fc_pass  = pass_pl[att];
            att++;
            lock_i = 1'b0;
        end else if (lock_cnt > 0) begin
            lock_cnt--;
            if (lock_cnt == 0) lock_i = 1'b1;
        end
        if (!pll_pwr_en_o) begin
            lock_i = 1'b0;
            lock_cnt = -1;
        end
        fchk_done_i = 1'b0;
        if (fchk_start_o) begin
            fc_cnt = 3;
        end else if (fc_cnt > 0) begin
            fc_cnt--;
            if (fc_cnt == 0) begin
                fchk_done_i = 1'b1;
                fchk_pass_i = fc_pass;
                fc_cnt = -1;
            end
        end
    end

    task automatic pulse_start(logic [SRC_W-1:0] s, logic [CFG_W-1:0] c, logic [WIN_W-1:0] w);
        @(negedge clk);
        src_sel_i = s; cfg_word_i = c; chk_window_i = w; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pll_clk_en_o == 0, "R1", "clk_en", pll_clk_en_o, 0);
        chk(pll_pwr_en_o == 0, "R1", "pwr_en", pll_pwr_en_o, 0);
        chk(sys_div_o == 0, "R1", "div", sys_div_o, 0);
        chk(src_sel_o == 0, "R1", "src", src_sel_o, 0);
        chk({busy_o, done_o, err_o} == 0, "R1", "busy/done/err", {busy_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Run B: clean pass from reset (R3 R4 R5 R6)
        lock_dly = '{5, 5, 5}; pass_pl = '{1, 1, 1}; att = 0;
        push(EV_BUSY, -1, "R2"); push(EV_SRC, 186, "R3"); push(EV_CFG, 61, "R4");
        push(EV_FCHK, 6, "R5"); push(EV_DONE, 4, "R6");
        pulse_start(2'd1, 32'hA5A5_1234, 16'd777);
        wait_idle();
        chk(pll_clk_en_o == 1, "R6", "clk_en after pass", pll_clk_en_o, 1);
        chk(cfg_word_o == 32'hA5A5_1234, "R4", "word", cfg_word_o, 32'hA5A5_1234);
        chk(src_sel_o == 1, "R3", "src", src_sel_o, 1);
        chk(fchk_window_o == 16'd777, "R5", "window", fchk_window_o, 777);
        chk(sys_div_o == 0, "R4", "div", sys_div_o, 0);
        repeat (30) @(negedge clk);
        chk(done_o == 1, "R10", "done sticky", done_o, 1);

        // Run C: fail verdict, lock timeout, then pass; extra start mid-run (R2 R7 R9)
        lock_dly = '{5, -1, 2}; pass_pl = '{0, 0, 1}; att = 0;
        push(EV_BUSY, -1, "R2"); push(EV_BYP, 0, "R2"); push(EV_PD, 120, "R2");
        push(EV_SRC, 66, "R3"); push(EV_CFG, 61, "R4"); push(EV_FCHK, 6, "R5");
        push(EV_PD, 4, "R7"); push(EV_CFG, 67, "R7");
        push(EV_PD, LOCK_TO + 1, "R7"); push(EV_CFG, 67, "R7");
        push(EV_FCHK, 3, "R5"); push(EV_DONE, 4, "R6");
        pulse_start(2'd2, 32'h0F0F_0042, 16'd99);
        chk(done_o == 0, "R10", "done cleared by start", done_o, 0);
        repeat (50) @(negedge clk);
        pulse_start(2'd3, 32'hDEAD_BEEF, 16'd5);
        wait_idle();
        chk(cfg_word_o == 32'h0F0F_0042, "R9", "word kept", cfg_word_o, 32'h0F0F_0042);
        chk(src_sel_o == 2, "R9", "src kept", src_sel_o, 2);
        chk(pll_clk_en_o == 1, "R6", "clk_en after retry pass", pll_clk_en_o, 1);

        // Run D: every attempt fails (R8)
        lock_dly = '{1, 1, 1}; pass_pl = '{0, 0, 0}; att = 0;
        push(EV_BUSY, -1, "R2"); push(EV_BYP, 0, "R2"); push(EV_PD, 120, "R2");
        push(EV_SRC, 66, "R3"); push(EV_CFG, 61, "R4"); push(EV_FCHK, 2, "R5");
        push(EV_PD, 4, "R7"); push(EV_CFG, 67, "R7"); push(EV_FCHK, 2, "R5");
        push(EV_PD, 4, "R7"); push(EV_CFG, 67, "R7"); push(EV_FCHK, 2, "R5");
        push(EV_PD, 4, "R8"); push(EV_ERR, 0, "R8");
        pulse_start(2'd3, 32'h1111_2222, 16'd10);
        wait_idle();
        chk(err_o == 1, "R8", "err", err_o, 1);
        chk(done_o == 0, "R10", "done low with err", done_o, 0);
        chk(pll_clk_en_o == 0, "R8", "clk_en", pll_clk_en_o, 0);
        chk(pll_pwr_en_o == 0, "R8", "pwr_en", pll_pwr_en_o, 0);
        chk(att == 3, "R8", "attempts", att, 3);
        repeat (20) @(negedge clk);
        chk(err_o == 1, "R10", "err sticky", err_o, 1);

        // Run E: start after error clears flags and runs cleanly (R10)
        lock_dly = '{3, 3, 3}; pass_pl = '{1, 1, 1}; att = 0;
        push(EV_BUSY, -1, "R2"); push(EV_SRC, 186, "R3"); push(EV_CFG, 61, "R4");
        push(EV_FCHK, 4, "R5"); push(EV_DONE, 4, "R6");
        pulse_start(2'd1, 32'h7777_0001, 16'd3);
        chk(err_o == 0, "R10", "err cleared by start", err_o, 0);
        wait_idle();
        chk(done_o == 1, "R10", "done", done_o, 1);
        chk(sb.size() == 0, "R7", "scoreboard empty", sb.size(), 0);
        summary();
    end
endmodule